// File: doc/BRIEF.md
# Half-Duplex Debug Port Engine

This block is the pin-level engine of a two-wire debug port for a small microcontroller target. It drives a debug clock and a reset line toward the target. It shares a single data line in both directions: an output level plus an output enable, and an input level sampled back from the pad. The block runs the target reset choreography that enters debug mode and the one that leaves it. It also moves single 8-bit bytes across the shared line, either out to the target or in from it, and never both in the same transfer.

Upstream logic issues one operation at a time. It holds `req_valid` with a 2-bit operation code and an outgoing byte. The engine takes the request on any cycle in which it is not busy. When the last clock edge of the operation has been produced, the engine pulses `done`. A received byte appears on `rd_data` in that same cycle. The bit rate comes from the `HALF_DIV` parameter, which gives the number of system clocks per half period of the debug clock (minimum 1). Choose it so that the debug clock stays below about 30 MHz. Command meaning and framing belong to the layer above.

Top module: `dbg_wire_phy`

## Requirements
- R1: After reset, and whenever idle, the debug clock is low, the data output enable is low and the target reset output is high (released).
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the operation ends. `done` is a single-cycle pulse in the cycle that `busy` falls. From acceptance to `done` takes exactly P×HALF_DIV system clocks, where P is 5 for entry, 2 for exit and 16 for a byte transfer.
- R3: A byte write (code 2) drives the data enable high for the whole transfer. It gives 8 rising debug-clock edges and presents the byte most-significant bit first. The data output changes only while the debug clock is low, so it is stable across every high phase.
- R4: A byte read (code 3) keeps the data enable low for the whole transfer. The first rising debug-clock edge comes exactly HALF_DIV cycles after acceptance. The line is sampled at each of the 8 falling edges, most-significant bit first, and the assembled byte appears on `rd_data` together with `done`.
- R5: Debug entry (code 0) holds target reset low and gives exactly two positive debug-clock pulses while it is low. It then releases reset with the debug clock low.
- R6: Debug exit (code 1) pulls target reset low for two half periods and then releases it, with no debug-clock pulse.
- R7: A request raised while `busy` is high is ignored and leaves no trace on any pin, either during the running operation or after it.
- R8: The debug clock and a low target reset occur only while `busy` is high.
- R9: `rd_data` keeps its value through write, entry and exit operations and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_cmd | input | 2 | Operation code: 0 entry, 1 exit, 2 write byte, 3 read byte |
| req_data | input | DATA_W | Byte to send on a write |
| req_ready | output | 1 | High when a request would be taken |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| rd_data | output | DATA_W | Byte captured by the last read |
| dclk_o | output | 1 | Debug clock to the target |
| dio_o | output | 1 | Data line output level |
| dio_oe | output | 1 | Data line output enable |
| dio_i | input | 1 | Data line level from the pad |
| tgt_rst_n_o | output | 1 | Target reset, active low |

## Verification
On every cycle the assertions check these properties: the clock is quiet and reset is released whenever the engine is idle, written data is stable while the clock is high, the line is released before the first clock of a read, an exit never pulses the clock, and a request arriving during an operation cannot alter it. The bench scenarios are the only place that shows the values themselves. These are the bit order of written and read bytes, the exact count of two clock pulses inside the entry reset, the operation lengths in system clocks, and the holding of `rd_data` across other operations. The effect of an asynchronous reset mid-transfer is also only visible there.

// File: rtl/dbg_wire_pkg.sv
package dbg_wire_pkg;

  typedef enum logic [1:0] {
    OP_ENTER = 2'd0,
    OP_EXIT  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  localparam int ENTER_PHASES = 5;
  localparam int EXIT_PHASES  = 2;

  // Number of half periods an operation lasts.
  function automatic int op_phases(op_e op, int bits);
    case (op)
      OP_ENTER: op_phases = ENTER_PHASES;
      OP_EXIT:  op_phases = EXIT_PHASES;
      default:  op_phases = 2 * bits;
    endcase
  endfunction

  // Debug clock level during a given half period of an operation.
  function automatic logic clk_level(op_e op, int ph);
    case (op)
      OP_ENTER: clk_level = (ph == 1) || (ph == 3);
      OP_EXIT:  clk_level = 1'b0;
      default:  clk_level = (ph % 2) == 1;
    endcase
  endfunction

  function automatic logic is_byte_op(op_e op);
    is_byte_op = (op == OP_WRITE) || (op == OP_READ);
  endfunction

endpackage

// File: rtl/dbg_wire_tick.sv
module dbg_wire_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg_wire_shift.sv
module dbg_wire_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic         msb,
  output logic [W-1:0] nxt
);
  logic [W-1:0] sr;

  assign nxt = {sr[W-2:0], ser_in};
  assign msb = sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= nxt;
  end
endmodule

// File: rtl/dbg_wire_phy.sv
module dbg_wire_phy
  import dbg_wire_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              dclk_o,
  output logic              dio_o,
  output logic              dio_oe,
  input  logic              dio_i,
  output logic              tgt_rst_n_o
);
  localparam int MAX_PH = (2 * DATA_W > ENTER_PHASES) ? 2 * DATA_W : ENTER_PHASES;
  localparam int PH_W   = $clog2(MAX_PH);

  op_e             op_q;
  op_e             req_op;
  logic            busy_q, dclk_q, oe_q, rstn_q, done_q;
  logic [PH_W-1:0] ph_q, ph_next;
  logic [DATA_W-1:0] rd_q, sh_nxt;

  // Named internal events for the checker.
  logic accept, tick, last_ph, op_end, shift_en, sh_msb;

  assign req_op   = op_e'(req_cmd);
  assign accept   = req_valid && !busy_q;
  assign ph_next  = ph_q + 1'b1;
  assign last_ph  = (ph_q == PH_W'(op_phases(op_q, DATA_W) - 1));
  assign op_end   = busy_q && tick && last_ph;
  assign shift_en = busy_q && tick && ph_q[0] && is_byte_op(op_q);

  dbg_wire_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .tick (tick)
  );

  dbg_wire_shift #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val((req_op == OP_WRITE) ? req_data : '0),
    .shift   (shift_en),
    .ser_in  (dio_i),
    .msb     (sh_msb),
    .nxt     (sh_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_ENTER;
      ph_q   <= '0;
      dclk_q <= 1'b0;
      oe_q   <= 1'b0;
      rstn_q <= 1'b1;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= req_op;
      ph_q   <= '0;
      dclk_q <= 1'b0;
      oe_q   <= (req_op == OP_WRITE);
      rstn_q <= is_byte_op(req_op);
    end else if (op_end) begin
      busy_q <= 1'b0;
      dclk_q <= 1'b0;
      oe_q   <= 1'b0;
      rstn_q <= 1'b1;
    end else if (busy_q && tick) begin
      ph_q   <= ph_next;
      dclk_q <= clk_level(op_q, int'(ph_next));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= op_end;
      if (op_end && op_q == OP_READ) rd_q <= sh_nxt;
    end
  end

  assign req_ready   = !busy_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign rd_data     = rd_q;
  assign dclk_o      = dclk_q;
  assign dio_oe      = oe_q;
  assign dio_o       = sh_msb && oe_q;
  assign tgt_rst_n_o = rstn_q;
endmodule

// File: rtl/dbg_wire_phy_chk.sv
module dbg_wire_phy_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       accept,
  input logic       op_end,
  input logic [1:0] op_q,
  input logic       dclk_o,
  input logic       dio_o,
  input logic       dio_oe,
  input logic       tgt_rst_n_o
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dio_oe && tgt_rst_n_o));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r2_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    op_end |=> (done && !busy));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && dio_oe) |-> $stable(dio_o));

  a_r4_released_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dclk_o) && op_q == 2'd3) |-> (!dio_oe && !$past(dio_oe)));

  a_r6_exit_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == 2'd1) |-> !dclk_o);

  a_r7_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(op_q));

  a_r8_clock_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dclk_o);

  a_r8_reset_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n_o |-> busy);
endmodule

bind dbg_wire_phy dbg_wire_phy_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .done       (done),
  .accept     (accept),
  .op_end     (op_end),
  .op_q       (op_q),
  .dclk_o     (dclk_o),
  .dio_o      (dio_o),
  .dio_oe     (dio_oe),
  .tgt_rst_n_o(tgt_rst_n_o)
);

// File: tb/tb_dbg_wire_phy.sv
module tb_dbg_wire_phy;
  localparam int HD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_cmd = 2'd0;
  logic [7:0] req_data = 8'h00;
  logic       req_ready, busy, done, dclk_o, dio_o, dio_oe, tgt_rst_n_o;
  logic [7:0] rd_data;
  logic       dio_i;

  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dbg_wire_phy #(.HALF_DIV(HD), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_data(req_data), .req_ready(req_ready), .busy(busy), .done(done),
    .rd_data(rd_data), .dclk_o(dclk_o), .dio_o(dio_o), .dio_oe(dio_oe),
    .dio_i(dio_i), .tgt_rst_n_o(tgt_rst_n_o)
  );

  // Pin monitor and target model.
  logic       mon_clr = 1'b0;
  logic       dclk_prev = 1'b0;
  logic [7:0] tgt_byte = 8'h00;
  logic [7:0] cap;
  logic       oe_hi, rst_lo, oe_at_rise;
  int         cyc, rises, rst_rises, first_rise;

  always @(posedge clk) begin
    if (mon_clr) begin
      cyc <= 0; rises <= 0; rst_rises <= 0; first_rise <= -1;
      cap <= 8'h00; oe_hi <= 1'b0; rst_lo <= 1'b0; oe_at_rise <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (dio_oe) oe_hi <= 1'b1;
      if (!tgt_rst_n_o) rst_lo <= 1'b1;
      if (dclk_o && !dclk_prev) begin
        rises <= rises + 1;
        if (rises == 0) begin
          first_rise <= cyc;
          oe_at_rise <= dio_oe;
        end
        if (!tgt_rst_n_o) rst_rises <= rst_rises + 1;
        if (dio_oe) cap <= {cap[6:0], dio_o};
      end
    end
    dclk_prev <= dclk_o;
  end

  // Target presents bit 7-(n-1) after the n-th rising edge.
  assign dio_i = (rises >= 1 && rises <= 8) ? tgt_byte[3'(8 - rises)] : 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request; returns cycles from acceptance to done and busy-low count.
  task automatic run_op(input logic [1:0] cmd, input logic [7:0] din,
                        output int n, output int busy_gaps);
    @(negedge clk);
    mon_clr = 1'b1; req_valid = 1'b1; req_cmd = cmd; req_data = din;
    @(negedge clk);
    mon_clr = 1'b0; req_valid = 1'b0;
    n = 0; busy_gaps = 0;
    while (!done && n < 1000) begin
      if (!busy) busy_gaps++;
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int phases_of(input logic [1:0] cmd);
    case (cmd)
      2'd0: return 5;
      2'd1: return 2;
      default: return 16;
    endcase
  endfunction

  // {cmd, data in (or target byte), expected}
  localparam logic [17:0] VEC [0:8] = '{
    {2'd0, 8'h00, 8'h02},
    {2'd2, 8'hA5, 8'hA5},
    {2'd3, 8'h3C, 8'h3C},
    {2'd2, 8'h80, 8'h80},
    {2'd3, 8'h01, 8'h01},
    {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h7E, 8'h7E},
    {2'd3, 8'hFF, 8'hFF},
    {2'd3, 8'h96, 8'h96}
  };

  initial begin : watchdog
    #2_000_000;
    bad++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] last_rd;
    int n, gaps;
    last_rd = 8'h00;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!dclk_o && !dio_oe && tgt_rst_n_o && !busy && !done, "R1 reset pins",
          {dclk_o, dio_oe, tgt_rst_n_o, busy, done}, 5'b00100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !busy && !dclk_o && tgt_rst_n_o, "R1 idle after reset",
          {req_ready, busy, dclk_o, tgt_rst_n_o}, 4'b1001);

    for (int i = 0; i < 9; i++) begin
      logic [1:0] c;
      logic [7:0] d, e;
      {c, d, e} = VEC[i];
      tgt_byte = d;
      run_op(c, d, n, gaps);
      check(n == phases_of(c) * HD, "R2 duration", n, phases_of(c) * HD);
      check(gaps == 0, "R2 busy held", gaps, 0);
      @(negedge clk);
      check(!done && !busy && !dclk_o && tgt_rst_n_o && !dio_oe, "R2 done single / R1 idle",
            {done, busy, dclk_o, tgt_rst_n_o, dio_oe}, 5'b00010);
      case (c)
        2'd2: begin
          check(cap == e && rises == 8, "R3 write byte MSB first", {rises, cap}, {8, e});
          check(oe_hi, "R3 enable driven", oe_hi, 1);
          check(rd_data == last_rd, "R9 rd_data held over write", rd_data, last_rd);
        end
        2'd3: begin
          check(rd_data == e && rises == 8, "R4 read byte MSB first", {rises, rd_data}, {8, e});
          check(!oe_hi && !oe_at_rise, "R4 line released", oe_hi, 0);
          check(first_rise == HD, "R4 first rise after half period", first_rise, HD);
          last_rd = e;
        end
        2'd0: begin
          check(rst_lo && rst_rises == 2 && rises == 2, "R5 two pulses in reset",
                rst_rises, 2);
          check(tgt_rst_n_o && !dclk_o, "R5 reset released, clock low", tgt_rst_n_o, 1);
          check(rd_data == last_rd, "R9 rd_data held over entry", rd_data, last_rd);
        end
        default: begin
          check(rst_lo && rises == 0, "R6 exit without clock", rises, 0);
          check(rd_data == last_rd, "R9 rd_data held over exit", rd_data, last_rd);
        end
      endcase
    end

    // R7: entry request raised during a read must be ignored.
    tgt_byte = 8'h5A;
    @(negedge clk);
    mon_clr = 1'b1; req_valid = 1'b1; req_cmd = 2'd3;
    @(negedge clk);
    mon_clr = 1'b0; req_valid = 1'b0;
    repeat (7) @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 1000) @(negedge clk);
    check(rd_data == 8'h5A && rises == 8, "R7 read unaffected", rd_data, 8'h5A);
    repeat (40) @(negedge clk);
    check(!rst_lo && rises == 8 && !busy, "R7 ignored request left no trace",
          {rst_lo, rises}, 8);

    // R8 / R1: asynchronous reset in the middle of a write returns pins to idle.
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd2; req_data = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(busy, "R8 busy during write", busy, 1);
    rst_n = 1'b0;
    #1;
    check(!busy && !dclk_o && !dio_oe && tgt_rst_n_o && rd_data == 8'h00,
          "R1 reset mid-transfer", {busy, dclk_o, dio_oe, tgt_rst_n_o}, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule